// File: doc/BRIEF.md
# Strobed Byte-Wide Register Port

This block is the device end of a narrow host port that reaches a bank of 64 six-bit control registers. The host drives an 8-bit code. Bit 7 of that code is a strobe. The other seven bits hold either a register address or a data value, and the value range tells them apart. The device takes in a code on a rising edge of the strobe. The host must hold the low bits steady while the strobe rises.

To write a register, the host drives four codes in turn: the address code, the same code with the strobe set, the data code, and the data code with the strobe set. To read a register, the host only presents and strobes the address. From then on, the seven-bit readback output shows the content of the addressed register. A data strobe always targets the address latched most recently. The host port is asynchronous to the device clock, so the inputs pass through a two-flop synchronizer before the strobe edge is detected. The full register bank is also brought out flat so that downstream logic can use the contents.

Top module: `strobe_regport`

## Requirements
- R1: After reset, every register holds 0, no address is latched and `port_rd` reads 0.
- R2: A code is accepted only when the strobe (bit 7) rises from 0 to 1. While bit 7 stays high, changes to bits 6:0 have no effect on the registers or on the latched address.
- R3: An accepted code in 0x40 to 0x7F latches register index (code minus 0x40), that is, bits 5:0. `port_rd` then shows that register's content.
- R4: An accepted code in 0x00 to 0x3F writes its bits 5:0 into the register at the latched index.
- R5: A data strobe that arrives before any address has been latched since reset is ignored, and no register changes.
- R6: `port_rd` is 0 while no address is latched. Otherwise it is {1'b0, register[latched index]}, so bit 6 is always 0.
- R7: A strobe edge driven on the port takes effect on the third rising clock edge after the change: two edges for the synchronizer and one edge for the update. It is not visible after only two edges.
- R8: The latched address persists across data writes. A data write changes only the addressed register, and a later address strobe moves the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_in | input | 8 | Host code: bit 7 is the strobe, bits 6:0 are an address or data code |
| port_rd | output | 7 | Readback of the latched register, bit 6 always 0 |
| reg_flat | output | 384 | All registers flattened, register i at bits 6*i+5 : 6*i |

## Verification
A change on the port reaches the latched address or the register bank on the third rising edge after the change. The readback follows on the same edge, because it is a combinational view of that state. Each host step in the bench is therefore held for four clock cycles, and results are sampled on a falling edge, well after the update. One directed test samples the readback after exactly two edges, where the old value is still due, and again after the third edge, where the new value must appear. This brackets the latency from both sides.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int PORT_W  = 8;
  localparam int CODE_W  = PORT_W - 1;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 6;
  localparam int RD_W    = 7;
  localparam int REG_CNT = 1 << ADDR_W;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2
  } code_kind_e;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/regport_decode.sv
module regport_decode
  import regport_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [CW-1:0] code,
  output logic          stb_edge,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] addr_q,
  output logic          addr_vld
);
  logic          stb_prev_q;
  code_kind_e    kind;
  logic [AW-1:0] addr_d;
  logic          vld_d;

  assign stb_edge = strobe & ~stb_prev_q;

  always_comb begin
    if (!stb_edge)            kind = KIND_NONE;
    else if (code[CW-1])      kind = KIND_ADDR;
    else                      kind = KIND_DATA;
  end

  always_comb begin
    addr_d  = addr_q;
    vld_d   = addr_vld;
    wr_en   = 1'b0;
    wr_data = code[DW-1:0];
    case (kind)
      KIND_ADDR: begin
        addr_d = code[AW-1:0];
        vld_d  = 1'b1;
      end
      KIND_DATA: wr_en = addr_vld;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= 1'b0;
      addr_q     <= '0;
      addr_vld   <= 1'b0;
    end else begin
      stb_prev_q <= strobe;
      if (kind == KIND_ADDR) begin
        addr_q   <= addr_d;
        addr_vld <= vld_d;
      end
    end
  end
endmodule

// File: rtl/regport_regfile.sv
module regport_regfile #(
  parameter int CNT = 64,
  parameter int AW  = 6,
  parameter int DW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [CNT*DW-1:0] flat
);
  logic [DW-1:0] mem [CNT];

  for (genvar i = 0; i < CNT; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= '0;
      else if (hit) mem[i] <= wr_data;
    end

    assign flat[i*DW +: DW] = mem[i];
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/strobe_regport.sv
module strobe_regport
  import regport_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_RD_W   = RD_W,
  localparam int L_CNT   = 1 << P_ADDR_W,
  localparam int L_CODE  = P_ADDR_W + 1,
  localparam int L_PORT  = L_CODE + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [L_PORT-1:0]         port_in,
  output logic [P_RD_W-1:0]         port_rd,
  output logic [L_CNT*P_DATA_W-1:0] reg_flat
);
  logic [1:0]          rst_pipe_q;
  logic                rst_ns;
  logic [L_PORT-1:0]   sync_q;
  logic [L_CODE-1:0]   sync_code;
  logic                stb_edge;
  logic                wr_en;
  logic [P_DATA_W-1:0] wr_data;
  logic [P_ADDR_W-1:0] addr_q;
  logic                addr_vld;
  logic [P_DATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  regport_sync #(.W(L_PORT)) u_sync (
    .clk(clk), .rst_n(rst_ns), .d(port_in), .q(sync_q)
  );

  assign sync_code = sync_q[L_CODE-1:0];

  regport_decode #(.CW(L_CODE), .AW(P_ADDR_W), .DW(P_DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_ns),
    .strobe(sync_q[L_PORT-1]), .code(sync_code),
    .stb_edge(stb_edge), .wr_en(wr_en), .wr_data(wr_data),
    .addr_q(addr_q), .addr_vld(addr_vld)
  );

  regport_regfile #(.CNT(L_CNT), .AW(P_ADDR_W), .DW(P_DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_ns),
    .wr_en(wr_en), .wr_addr(addr_q), .wr_data(wr_data),
    .rd_addr(addr_q), .rd_data(rd_data), .flat(reg_flat)
  );

  assign port_rd = addr_vld ? P_RD_W'(rd_data) : '0;
endmodule

// File: rtl/strobe_regport_chk.sv
module strobe_regport_chk #(
  parameter int CW   = 7,
  parameter int RW   = 7,
  parameter int FW   = 384
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stb_edge,
  input logic [CW-1:0] code,
  input logic          addr_vld,
  input logic [RW-1:0] port_rd,
  input logic [FW-1:0] reg_flat
);
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    stb_edge |=> !stb_edge);

  a_r2_no_edge_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_edge |=> $stable(reg_flat));

  a_r5_no_addr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(reg_flat));

  a_r3_addr_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_edge && code[CW-1]) |=> addr_vld);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |-> (port_rd == '0));

  a_r6_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd[RW-1] == 1'b0);
endmodule

bind strobe_regport strobe_regport_chk #(
  .CW(L_CODE), .RW(P_RD_W), .FW(L_CNT*P_DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_ns), .stb_edge(stb_edge), .code(sync_code),
  .addr_vld(addr_vld), .port_rd(port_rd), .reg_flat(reg_flat)
);

// File: tb/strobe_regport_bench.sv
module strobe_regport_bench;
  logic         clk;
  logic         rst_n;
  logic [7:0]   port_in;
  logic [6:0]   port_rd;
  logic [383:0] reg_flat;
  int checks;
  int errors;
  logic [5:0] model [64];

  strobe_regport u_strobe_regport (
    .clk(clk), .rst_n(rst_n), .port_in(port_in),
    .port_rd(port_rd), .reg_flat(reg_flat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {write?, index, value}
  localparam logic [12:0] VEC [10] = '{
    {1'b1, 6'd0,  6'h3F},
    {1'b1, 6'd63, 6'h2A},
    {1'b1, 6'd31, 6'h01},
    {1'b0, 6'd0,  6'h00},
    {1'b1, 6'd0,  6'h00},
    {1'b0, 6'd63, 6'h00},
    {1'b1, 6'd32, 6'h15},
    {1'b0, 6'd31, 6'h00},
    {1'b0, 6'd32, 6'h00},
    {1'b1, 6'd63, 6'h3F}
  };

  function automatic logic [383:0] model_flat();
    logic [383:0] f;
    for (int i = 0; i < 64; i++) f[i*6 +: 6] = model[i];
    return f;
  endfunction

  task automatic check_rd(input string req, input logic [6:0] exp);
    checks++;
    if (port_rd !== exp) begin
      errors++;
      $display("FAIL %s port_rd actual=%h expected=%h", req, port_rd, exp);
    end
  endtask

  task automatic check_regs(input string req);
    checks++;
    if (reg_flat !== model_flat()) begin
      errors++;
      $display("FAIL %s reg_flat actual=%h expected=%h", req, reg_flat, model_flat());
    end
  endtask

  task automatic step(input logic [7:0] b);
    @(negedge clk);
    port_in = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_write(input logic [5:0] idx, input logic [5:0] val);
    step({2'b01, idx});
    step({2'b11, idx});
    step({2'b00, val});
    step({2'b10, val});
    model[idx] = val;
  endtask

  task automatic host_read(input logic [5:0] idx);
    step({2'b01, idx});
    step({2'b11, idx});
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    checks = 0;
    errors = 0;
    for (int i = 0; i < 64; i++) model[i] = '0;
    port_in = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check_rd("R1", 7'h00);
    check_regs("R1");

    // R5 data strobe before any address is ignored
    step(8'h15);
    step(8'h95);
    check_regs("R5");
    check_rd("R5/R6 idle", 7'h00);

    // Table walk: R3 R4 R6 R8
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][12]) host_write(VEC[i][11:6], VEC[i][5:0]);
      else            host_read(VEC[i][11:6]);
      check_rd("R3/R6 readback", {1'b0, model[VEC[i][11:6]]});
      check_regs("R4/R8 bank");
    end

    // R8 address persists across several data writes
    host_write(6'd5, 6'h11);
    step(8'h00);
    step(8'h80);
    step(8'h11);
    step(8'h91);
    check_rd("R8 persist", 7'h11);
    check_regs("R8 persist");

    // R2 low bits change while strobe held high: no effect
    step(8'hA2);
    check_regs("R2 data while high");
    step(8'hC7);
    check_rd("R2 addr while high", 7'h11);

    // R7 latency: prepare reg 9, return to address 5
    host_write(6'd9, 6'h2A);
    host_read(6'd5);
    check_rd("R7 setup", 7'h11);
    step(8'h49);
    @(negedge clk);
    port_in = 8'hC9;
    repeat (2) @(negedge clk);
    check_rd("R7 two edges", 7'h11);
    @(negedge clk);
    check_rd("R7 third edge", 7'h2A);
    repeat (2) @(negedge clk);

    // R1 reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) model[i] = '0;
    check_regs("R1 mid reset");
    check_rd("R1 mid reset", 7'h00);
    port_in = 8'h00;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_rd("R1 after release", 7'h00);

    summary();
  end
endmodule